// File: doc/BRIEF.md
# Writeback Hazard Scoreboard Queue

This block is a short first-in first-out queue that holds the writeback records of instructions an in-order pipeline has issued but not yet retired. A record has one of four kinds: an arithmetic result with a destination register and a 32-bit value, a memory read with a destination register, a memory write, or a host-side action. The issue stage pushes one record per issued instruction. The writeback stage pops the oldest record, reads it from the head outputs and acts on it.

Two associative lookup ports, each driven by a 5-bit register index, report in the same cycle whether any record still in the queue will write that register. Issue logic feeds the two source operands of the next instruction into these ports. A hit on either port means a read-after-write hazard, and issue stalls. Only the arithmetic and memory-read kinds can raise a hit. A synchronous clear drops every record at once, for example when the pipeline is flushed.

Top module: `wb_scoreboard_queue`

## Requirements
- R1: After reset the queue is empty (`empty`=1, `full`=0) and both lookup outputs are 0.
- R2: The head outputs show the kind, destination and data of the oldest held record, exactly as they were pushed, and records leave in push order. The kind codes are 0 = arithmetic, 1 = memory read, 2 = memory write and 3 = host action. The head outputs are all zero while the queue is empty.
- R3: `full` is 1 when `DEPTH` records are held. A push offered while `full` is 1 before the clock edge is dropped, even if a pop happens in the same cycle.
- R4: A pop requested while the queue is empty is ignored, and the queue stays empty.
- R5: A lookup port returns 1 when at least one held record of kind 0 or 1 has a destination equal to the port's index.
- R6: Records of kind 2 or 3 never cause a hit, whatever destination value they carry.
- R7: The two lookup ports are evaluated independently in the same cycle, each on its own index.
- R8: Slots that are empty, or whose record has already been popped, never cause a hit.
- R9: When a push and a pop happen in the same cycle, the lookups in that cycle reflect the records held before the edge. After the edge the popped record no longer hits, the pushed record does, and the occupancy is unchanged.
- R10: `clear` empties the queue in one cycle and takes priority over a push or pop in the same cycle. Afterwards both lookup outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous flush of all records |
| push_valid | input | 1 | Push request |
| push_kind | input | 2 | Kind code of the pushed record |
| push_dest | input | 5 | Destination register of the pushed record |
| push_data | input | 32 | Data value of the pushed record |
| pop_req | input | 1 | Pop request for the head record |
| head_kind | output | 2 | Kind of the oldest record |
| head_dest | output | 5 | Destination of the oldest record |
| head_data | output | 32 | Data of the oldest record |
| full | output | 1 | Queue holds DEPTH records |
| empty | output | 1 | Queue holds no record |
| look_a_idx | input | 5 | Register index for lookup port A |
| look_a_hit | output | 1 | Port A: a held record writes that register |
| look_b_idx | input | 5 | Register index for lookup port B |
| look_b_hit | output | 1 | Port B: a held record writes that register |

## Verification
The assertions assume that `clear`, `push_valid` and `pop_req` always have known values after reset. They also assume that a pop requested on an empty queue, or a push offered to a full one, is legal traffic that the block must absorb, not a forbidden input. The bench drives every input from time zero and deliberately issues such pops and pushes, both in directed steps and in a long randomised phase. It also mixes clears with same-cycle pushes and pops, so the overflow, underflow and flush properties are exercised against inputs that stay inside those assumptions. Destination and lookup values in the random phase are drawn from a narrow range so that hits are frequent. A separate sweep walks every index on both ports against a queue that holds records of mixed kinds.

// File: rtl/wbq_pkg.sv
// Shared types for the writeback scoreboard queue.
// Assumes a 5-bit register index and a 32-bit data value per record.
package wbq_pkg;

    localparam int REG_IDX_W = 5;
    localparam int WB_DATA_W = 32;

    typedef enum logic [1:0] {
        WB_KIND_ALU   = 2'd0,
        WB_KIND_LOAD  = 2'd1,
        WB_KIND_STORE = 2'd2,
        WB_KIND_HOST  = 2'd3
    } wb_kind_e;

    typedef struct packed {
        wb_kind_e               kind;
        logic [REG_IDX_W-1:0]   dest;
        logic [WB_DATA_W-1:0]   data;
    } wb_entry_t;

    // True for record kinds that will write a register at writeback.
    function automatic logic kind_writes_reg(input wb_kind_e k);
        return (k == WB_KIND_ALU) || (k == WB_KIND_LOAD);
    endfunction

endpackage

// File: rtl/wbq_ctrl.sv
// Pointer and occupancy control for the scoreboard queue.
// Decides which push and pop requests are accepted, and keeps the read pointer,
// the write pointer and the occupancy count. Clear overrides push and pop.
// Assumes DEPTH >= 2.
module wbq_ctrl #(
    parameter int DEPTH = 2,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push_fire,
    output logic             pop_fire,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] occupancy,
    output logic             full,
    output logic             empty
);

    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] MAX_OCC   = CNT_W'(DEPTH);

    // Occupancy flags, taken from the count before the edge.
    always_comb begin
        full  = (occupancy == MAX_OCC);
        empty = (occupancy == '0);
    end

    // Request acceptance: gated by the flags and overridden by clear.
    always_comb begin
        push_fire = push_req && !full && !clear;
        pop_fire  = pop_req && !empty && !clear;
    end

    // Pointer and count update, with a wrap at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            occupancy <= '0;
        end else begin
            if (push_fire)
                wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
            if (pop_fire)
                rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
            case ({push_fire, pop_fire})
                2'b10:   occupancy <= occupancy + 1'b1;
                2'b01:   occupancy <= occupancy - 1'b1;
                default: occupancy <= occupancy;
            endcase
        end
    end

    assert_occupancy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= MAX_OCC);

    assert_full_drops_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !pop_req && !clear) |=> full);

    assert_empty_ignores_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !push_req && !clear) |=> empty);

    assert_swap_keeps_occupancy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && !full && !empty && !clear) |=> $stable(occupancy));

    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> empty);

endmodule

// File: rtl/wbq_store.sv
// Record storage for the scoreboard queue.
// Each slot holds one record and a valid bit. A slot is written and marked valid
// on an accepted push, and marked invalid on an accepted pop or on clear.
// Assumes the control never pushes and pops the same slot in one cycle.
module wbq_store
    import wbq_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push_fire,
    input  logic             pop_fire,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PTR_W-1:0] rd_ptr,
    input  wb_entry_t        push_entry,
    output wb_entry_t        slot_entry [DEPTH],
    output logic [DEPTH-1:0] slot_valid,
    output wb_entry_t        head_entry
);

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        localparam logic [PTR_W-1:0] SLOT_ID = PTR_W'(s);

        // Slot valid bit: set by a push into this slot, cleared by a pop from it.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                slot_valid[s] <= 1'b0;
            else if (push_fire && wr_ptr == SLOT_ID)
                slot_valid[s] <= 1'b1;
            else if (pop_fire && rd_ptr == SLOT_ID)
                slot_valid[s] <= 1'b0;
        end

        // Slot payload: captured on a push into this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_entry[s] <= '0;
            else if (push_fire && wr_ptr == SLOT_ID)
                slot_entry[s] <= push_entry;
        end

        assert_no_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (push_fire && wr_ptr == SLOT_ID) |-> !slot_valid[s]);
    end

    // Head view: the oldest record, or zero when that slot holds nothing.
    always_comb begin
        head_entry = slot_valid[rd_ptr] ? slot_entry[rd_ptr] : '0;
    end

endmodule

// File: rtl/wbq_probe.sv
// One associative lookup port of the scoreboard queue.
// Reports whether any valid slot holds a register-writing record whose
// destination equals the probe index. Assumes the slot valid bits are current.
module wbq_probe
    import wbq_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  wb_entry_t            slot_entry [DEPTH],
    input  logic [DEPTH-1:0]     slot_valid,
    input  logic [REG_IDX_W-1:0] probe_idx,
    output logic                 hit
);

    logic [DEPTH-1:0] slot_match;

    // Per-slot match: valid, writes a register, same destination.
    always_comb begin
        for (int s = 0; s < DEPTH; s++) begin
            slot_match[s] = slot_valid[s]
                         && kind_writes_reg(slot_entry[s].kind)
                         && (slot_entry[s].dest == probe_idx);
        end
    end

    // Reduce the per-slot matches to one hit.
    always_comb begin
        hit = |slot_match;
    end

    assert_hit_needs_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (slot_valid != '0));

endmodule

// File: rtl/wb_scoreboard_queue.sv
// Writeback scoreboard queue: a FIFO of pending writeback records with two
// independent lookup ports for read-after-write hazard detection.
// Assumes the issue side pushes at most one record per cycle and the
// writeback side pops at most one. Lookups see the state before the edge.
module wb_scoreboard_queue
    import wbq_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 push_valid,
    input  logic [1:0]           push_kind,
    input  logic [REG_IDX_W-1:0] push_dest,
    input  logic [WB_DATA_W-1:0] push_data,
    input  logic                 pop_req,
    output logic [1:0]           head_kind,
    output logic [REG_IDX_W-1:0] head_dest,
    output logic [WB_DATA_W-1:0] head_data,
    output logic                 full,
    output logic                 empty,
    input  logic [REG_IDX_W-1:0] look_a_idx,
    output logic                 look_a_hit,
    input  logic [REG_IDX_W-1:0] look_b_idx,
    output logic                 look_b_hit
);

    logic             push_fire;
    logic             pop_fire;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] occupancy;
    wb_entry_t        push_entry;
    wb_entry_t        head_entry;
    wb_entry_t        slot_entry [DEPTH];
    logic [DEPTH-1:0] slot_valid;

    logic [REG_IDX_W-1:0] look_idx [NUM_PORTS];
    logic [NUM_PORTS-1:0] look_hit;

    // Pack the push fields into one record.
    always_comb begin
        push_entry.kind = wb_kind_e'(push_kind);
        push_entry.dest = push_dest;
        push_entry.data = push_data;
    end

    // Unpack the head record onto the ports.
    always_comb begin
        head_kind = head_entry.kind;
        head_dest = head_entry.dest;
        head_data = head_entry.data;
    end

    // Gather the lookup ports into arrays for the generated probes.
    always_comb begin
        look_idx[0] = look_a_idx;
        look_idx[1] = look_b_idx;
        look_a_hit  = look_hit[0];
        look_b_hit  = look_hit[1];
    end

    wbq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .push_req  (push_valid),
        .pop_req   (pop_req),
        .push_fire (push_fire),
        .pop_fire  (pop_fire),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .occupancy (occupancy),
        .full      (full),
        .empty     (empty)
    );

    wbq_store #(.DEPTH(DEPTH)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .push_fire  (push_fire),
        .pop_fire   (pop_fire),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .push_entry (push_entry),
        .slot_entry (slot_entry),
        .slot_valid (slot_valid),
        .head_entry (head_entry)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_probe
        wbq_probe #(.DEPTH(DEPTH)) probe_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .slot_entry (slot_entry),
            .slot_valid (slot_valid),
            .probe_idx  (look_idx[p]),
            .hit        (look_hit[p])
        );
    end

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_valid_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slot_valid) == int'(occupancy));

    assert_empty_head_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (head_kind == 2'd0 && head_dest == '0 && head_data == '0));

    assert_clear_silences_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!look_a_hit && !look_b_hit));

    assert_empty_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (!look_a_hit && !look_b_hit));

endmodule

// File: tb/wb_scoreboard_queue_tb.sv
`timescale 1ns/1ps
// Bench for the writeback scoreboard queue: a behavioural queue model,
// compared with the design on every clock.
module wb_scoreboard_queue_tb_top;

    localparam int DEPTH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        push_valid = 1'b0;
    logic [1:0]  push_kind = 2'd0;
    logic [4:0]  push_dest = 5'd0;
    logic [31:0] push_data = 32'd0;
    logic        pop_req = 1'b0;
    logic [1:0]  head_kind;
    logic [4:0]  head_dest;
    logic [31:0] head_data;
    logic        full;
    logic        empty;
    logic [4:0]  look_a_idx = 5'd0;
    logic        look_a_hit;
    logic [4:0]  look_b_idx = 5'd0;
    logic        look_b_hit;

    int checks = 0;
    int failures = 0;

    // Model: each record is {kind, dest, data}.
    logic [38:0] model_q[$];

    always #4 clk = ~clk;

    wb_scoreboard_queue #(.DEPTH(DEPTH)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .push_valid (push_valid),
        .push_kind  (push_kind),
        .push_dest  (push_dest),
        .push_data  (push_data),
        .pop_req    (pop_req),
        .head_kind  (head_kind),
        .head_dest  (head_dest),
        .head_data  (head_data),
        .full       (full),
        .empty      (empty),
        .look_a_idx (look_a_idx),
        .look_a_hit (look_a_hit),
        .look_b_idx (look_b_idx),
        .look_b_hit (look_b_hit)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit model_hit(input logic [4:0] idx);
        foreach (model_q[i]) begin
            if (model_q[i][38:37] < 2'd2 && model_q[i][36:32] == idx)
                return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic compare_all();
        logic [38:0] exp_head;
        exp_head = (model_q.size() > 0) ? model_q[0] : '0;
        check(full == (model_q.size() == DEPTH), "R3 full", 64'(full), 64'(model_q.size() == DEPTH));
        check(empty == (model_q.size() == 0), "R4 empty", 64'(empty), 64'(model_q.size() == 0));
        check({head_kind, head_dest, head_data} == exp_head, "R2 head",
              64'({head_kind, head_dest, head_data}), 64'(exp_head));
        check(look_a_hit == model_hit(look_a_idx), "R5 port A", 64'(look_a_hit), 64'(model_hit(look_a_idx)));
        check(look_b_hit == model_hit(look_b_idx), "R7 port B", 64'(look_b_hit), 64'(model_hit(look_b_idx)));
    endtask

    task automatic model_update();
        int n;
        n = model_q.size();
        if (clear) begin
            model_q.delete();
        end else begin
            if (pop_req && n > 0)
                void'(model_q.pop_front());
            if (push_valid && n < DEPTH)
                model_q.push_back({push_kind, push_dest, push_data});
        end
    endtask

    // Called at a falling edge with inputs already driven.
    task automatic step();
        #1;
        compare_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic drive(input bit pv, input logic [1:0] k, input logic [4:0] d,
                         input logic [31:0] v, input bit pr, input bit cl);
        push_valid = pv;
        push_kind  = k;
        push_dest  = d;
        push_data  = v;
        pop_req    = pr;
        clear      = cl;
    endtask

    task automatic idle();
        drive(1'b0, 2'd0, 5'd0, 32'd0, 1'b0, 1'b0);
    endtask

    task automatic look(input logic [4:0] a, input logic [4:0] b);
        look_a_idx = a;
        look_b_idx = b;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        look(5'd0, 5'd0);
        #1;
        // R1: reset state
        check(empty == 1'b1, "R1 empty after reset", 64'(empty), 64'd1);
        check(full == 1'b0, "R1 full after reset", 64'(full), 64'd0);
        check(!look_a_hit && !look_b_hit, "R1 no hit after reset",
              64'({look_a_hit, look_b_hit}), 64'd0);
        @(negedge clk);

        // Fill with an arithmetic record (dest 5) and a memory read (dest 7).
        drive(1'b1, 2'd0, 5'd5, 32'hCAFE0001, 1'b0, 1'b0); step();
        drive(1'b1, 2'd1, 5'd7, 32'h0000BEEF, 1'b0, 1'b0); step();
        idle();
        look(5'd5, 5'd7);
        #1;
        // R7: both ports hit on different registers in one cycle
        check(look_a_hit && look_b_hit, "R7 dual hit", 64'({look_a_hit, look_b_hit}), 64'h3);
        step();

        // R3: push while full is dropped
        drive(1'b1, 2'd0, 5'd3, 32'h11111111, 1'b0, 1'b0); step();
        idle();
        look(5'd3, 5'd5);
        #1;
        check(head_dest == 5'd5 && full, "R3 push dropped when full", 64'({full, head_dest}), 64'h25);
        check(!look_a_hit, "R3 dropped record not visible", 64'(look_a_hit), 64'd0);
        step();

        // R3: push and pop together while full: push still dropped
        drive(1'b1, 2'd0, 5'd9, 32'h22222222, 1'b1, 1'b0); step();
        idle();
        look(5'd9, 5'd7);
        #1;
        check(!look_a_hit && look_b_hit && !full, "R3 full push with pop dropped",
              64'({look_a_hit, look_b_hit, full}), 64'h2);
        step();

        // R9: push dest 9 and pop the dest 7 record in one cycle
        drive(1'b1, 2'd0, 5'd9, 32'h33333333, 1'b1, 1'b0);
        look(5'd7, 5'd9);
        #1;
        check(look_a_hit && !look_b_hit, "R9 lookup sees pre-edge state",
              64'({look_a_hit, look_b_hit}), 64'h2);
        step();
        idle();
        #1;
        check(!look_a_hit && look_b_hit, "R9 lookup after swap",
              64'({look_a_hit, look_b_hit}), 64'h1);
        check(!look_a_hit, "R8 popped record no longer hits", 64'(look_a_hit), 64'd0);
        check(!empty && !full, "R9 occupancy unchanged", 64'({empty, full}), 64'd0);
        step();

        // R6: write and host records carrying dest 4 never hit
        drive(1'b0, 2'd0, 5'd0, 32'd0, 1'b0, 1'b1); step();
        drive(1'b1, 2'd2, 5'd4, 32'h44440000, 1'b0, 1'b0); step();
        drive(1'b1, 2'd3, 5'd4, 32'h00000001, 1'b0, 1'b0); step();
        idle();
        look(5'd4, 5'd4);
        #1;
        check(!look_a_hit && !look_b_hit && full, "R6 non-writers silent",
              64'({look_a_hit, look_b_hit, full}), 64'h1);
        step();

        // R4: pop on an empty queue
        drive(1'b0, 2'd0, 5'd0, 32'd0, 1'b0, 1'b1); step();
        drive(1'b0, 2'd0, 5'd0, 32'd0, 1'b1, 1'b0); step();
        idle();
        look(5'd0, 5'd4);
        #1;
        check(empty && !full, "R4 pop on empty ignored", 64'({empty, full}), 64'h2);
        step();

        // R10: clear wins over a same-cycle push
        drive(1'b1, 2'd0, 5'd2, 32'h55555555, 1'b0, 1'b0); step();
        drive(1'b1, 2'd0, 5'd3, 32'h66666666, 1'b1, 1'b1); step();
        idle();
        look(5'd2, 5'd3);
        #1;
        check(empty, "R10 clear empties", 64'(empty), 64'd1);
        check(!look_a_hit && !look_b_hit, "R10 no hit after clear",
              64'({look_a_hit, look_b_hit}), 64'd0);
        step();

        // Sweep every index on both ports over a mixed queue.
        drive(1'b1, 2'd0, 5'd12, 32'hABCD0000, 1'b0, 1'b0); step();
        drive(1'b1, 2'd1, 5'd0, 32'h0, 1'b0, 1'b0); step();
        idle();
        for (int i = 0; i < 32; i++) begin
            look(5'(i), 5'(31 - i));
            step();
        end
        drive(1'b1, 2'd3, 5'd12, 32'h7, 1'b1, 1'b0); step();
        idle();
        for (int i = 0; i < 32; i++) begin
            look(5'(31 - i), 5'(i));
            step();
        end

        // Random traffic with narrow destination and lookup ranges.
        for (int c = 0; c < 4000; c++) begin
            drive(($urandom_range(0, 99) < 60), 2'($urandom_range(0, 3)),
                  5'($urandom_range(0, 7)), $urandom(),
                  ($urandom_range(0, 99) < 50), ($urandom_range(0, 99) < 3));
            look(5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)));
            step();
        end

        idle();
        step();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule